// File: doc/BRIEF.md
# Bus Access Controller with Error-Driven Abort

This controller sits between a processor core (with a small cache) and a word-wide external memory bus. It runs the core's accesses on the bus: single reads, direct writes, posted writes, first- and second-level translation-table descriptor fetches, locked read-then-write pairs, and four-word cache line fills. A fill starts at the word the core asked for and wraps inside the aligned line.

The bus can answer any beat with an error instead of an acknowledge. When that happens the controller drops the access on the next cycle and decides what the core sees. Most access kinds raise a one-cycle abort with a status code. A posted write is the exception: its error is ignored. In a locked pair, an error on the read cancels the write and releases the lock. In a line fill, an error on any beat invalidates the line. The core is aborted only if the failing beat carried the requested word; otherwise it gets its data and carries on.

Top module: `xbus_abort_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_valid`, `rsp_done`, `rsp_abort`, `line_inval` and `fill_we` are 0.
- R2: A bus error on a single read, direct write or descriptor fetch makes `bus_valid` low in the next cycle, with exactly one bus beat issued. The core then gets one `rsp_abort` pulse.
- R3: `rsp_code` is valid with `rsp_abort` and is 0 otherwise. The codes are: 1 for a data access, 2 for a descriptor fetch (`req_kind` 3 or 4), and 3 for an instruction fetch (read or fill with `req_ifetch` = 1).
- R4: In a locked pair (`req_kind` 5), an error on the read beat means no write beat is issued, `bus_lock` is low in the next cycle, and the core is aborted. An error on the write beat also aborts.
- R5: A locked pair without error issues a read and then a write of `req_wdata` to the same address, with `bus_lock` high on both beats. It finishes with `rsp_done` and `rsp_rdata` equal to the read word.
- R6: A line fill (`req_kind` 6) issues four read beats. Their word index within the line is `req_addr[1:0]`, then +1, +2 and +3, modulo 4. Each acknowledged beat pulses `fill_we` with `fill_idx` equal to that index and `fill_data` equal to `bus_rdata`.
- R7: An error on the first fill beat (the requested word) gives `rsp_abort` and `line_inval` together, and no further beats are issued.
- R8: An error on fill beat 1, 2 or 3 gives `line_inval` and `rsp_done` with the requested word in `rsp_data`, no `rsp_abort`, and no further beats.
- R9: A posted write (`req_kind` 2) that receives a bus error ends with `rsp_done` and no `rsp_abort`.
- R10: `rsp_done` and `rsp_abort` are single-cycle pulses and never occur together. In the cycle after the pulse, `req_ready` is 1 again and a new request is accepted.
- R11: A single read or descriptor fetch without error issues one read beat at `req_addr`. It completes with `rsp_done` and `rsp_rdata` equal to the bus word. Direct and posted writes put `req_wdata` on `bus_wdata` with `bus_write` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe |
| req_kind | input | 3 | 0 read, 1 direct write, 2 posted write, 3 level-1 descriptor, 4 level-2 descriptor, 5 locked pair, 6 line fill |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_addr | input | AW | Word address (critical word for fills) |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, request accepted |
| rsp_done | output | 1 | Access completed without abort (pulse) |
| rsp_abort | output | 1 | Abort to the core (pulse) |
| rsp_code | output | 2 | Abort status code |
| rsp_rdata | output | DW | Read data, valid with rsp_done |
| bus_valid | output | 1 | Bus beat active |
| bus_write | output | 1 | Beat is a write |
| bus_lock | output | 1 | Beat belongs to a locked pair |
| bus_addr | output | AW | Beat word address |
| bus_wdata | output | DW | Beat write data |
| bus_rdata | input | DW | Read data from the bus |
| bus_ack | input | 1 | Beat completed |
| bus_err | input | 1 | Beat failed |
| fill_we | output | 1 | Cache line word write strobe |
| fill_idx | output | IW | Word index within the line |
| fill_data | output | DW | Word to write into the line |
| line_inval | output | 1 | Invalidate the line being filled (pulse) |

## Verification
The assertions assume two things about the bus. First, `bus_ack` and `bus_err` are never high together. Second, a response is given only while `bus_valid` is high. The stimulus meets both: the bench's bus responder looks at `bus_valid` each cycle, drives exactly one of the two for that beat, and clears both whenever no beat is active. The assertions also assume that `req_kind` stays within codes 0 to 6. Both the random requests and the directed corner cases (an error on every fill beat with a wrapping critical word, an error on either half of a locked pair, a posted write with an error) draw only from that set.

// File: rtl/xbac_pkg.sv
package xbac_pkg;

    typedef enum logic [2:0] {
        K_READ      = 3'd0,
        K_WR_DIRECT = 3'd1,
        K_WR_POSTED = 3'd2,
        K_DESC_L1   = 3'd3,
        K_DESC_L2   = 3'd4,
        K_LOCKED    = 3'd5,
        K_FILL      = 3'd6
    } acc_kind_e;

    typedef enum logic [1:0] {
        AB_NONE   = 2'd0,
        AB_DATA   = 2'd1,
        AB_DESC   = 2'd2,
        AB_IFETCH = 2'd3
    } abort_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_LOCKW,
        ST_FILL
    } ctl_state_e;

    function automatic logic kind_writes(acc_kind_e k);
        return (k == K_WR_DIRECT) || (k == K_WR_POSTED);
    endfunction

    function automatic logic kind_abortable(acc_kind_e k);
        return k != K_WR_POSTED;
    endfunction

    function automatic abort_code_e code_for(acc_kind_e k, logic ifetch);
        if (k == K_DESC_L1 || k == K_DESC_L2)
            return AB_DESC;
        else if (ifetch && (k == K_READ || k == K_FILL))
            return AB_IFETCH;
        else
            return AB_DATA;
    endfunction

endpackage

// File: rtl/xbac_fsm.sv
module xbac_fsm
    import xbac_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    localparam int IW = $clog2(LINE_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_fire,
    input  acc_kind_e     req_kind,
    input  logic          bus_ack,
    input  logic          bus_err,
    output ctl_state_e    state_q,
    output acc_kind_e     kind_q,
    output logic [IW-1:0] beat_q,
    output logic          fin_ok,
    output logic          fin_abort,
    output logic          fin_inval,
    output logic          cap_data
);

    ctl_state_e    state_d;
    logic [IW-1:0] beat_d;
    logic          last_beat;

    assign last_beat = (beat_q == IW'(LINE_WORDS - 1));

    always_comb begin
        state_d   = state_q;
        beat_d    = beat_q;
        fin_ok    = 1'b0;
        fin_abort = 1'b0;
        fin_inval = 1'b0;
        cap_data  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire) begin
                    state_d = (req_kind == K_FILL) ? ST_FILL : ST_SINGLE;
                    beat_d  = '0;
                end
            end
            ST_SINGLE: begin
                if (bus_err) begin
                    state_d   = ST_IDLE;
                    fin_abort = kind_abortable(kind_q);
                    fin_ok    = !kind_abortable(kind_q);
                end else if (bus_ack) begin
                    cap_data = !kind_writes(kind_q);
                    if (kind_q == K_LOCKED) begin
                        state_d = ST_LOCKW;
                    end else begin
                        state_d = ST_IDLE;
                        fin_ok  = 1'b1;
                    end
                end
            end
            ST_LOCKW: begin
                if (bus_err) begin
                    state_d   = ST_IDLE;
                    fin_abort = 1'b1;
                end else if (bus_ack) begin
                    state_d = ST_IDLE;
                    fin_ok  = 1'b1;
                end
            end
            ST_FILL: begin
                if (bus_err) begin
                    state_d   = ST_IDLE;
                    fin_inval = 1'b1;
                    fin_abort = (beat_q == '0);
                    fin_ok    = (beat_q != '0);
                end else if (bus_ack) begin
                    cap_data = (beat_q == '0);
                    if (last_beat) begin
                        state_d = ST_IDLE;
                        fin_ok  = 1'b1;
                    end else begin
                        beat_d = beat_q + IW'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= K_READ;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            if (req_fire)
                kind_q <= req_kind;
        end
    end

endmodule

// File: rtl/xbac_busdrv.sv
module xbac_busdrv
    import xbac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LINE_WORDS = 4,
    localparam int IW = $clog2(LINE_WORDS)
) (
    input  ctl_state_e    state_q,
    input  acc_kind_e     kind_q,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] wdata_q,
    input  logic [IW-1:0] beat_q,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_valid,
    output logic          bus_write,
    output logic          bus_lock,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          fill_we,
    output logic [IW-1:0] fill_idx,
    output logic [DW-1:0] fill_data
);

    logic in_fill;

    assign in_fill   = (state_q == ST_FILL);
    assign bus_valid = (state_q != ST_IDLE);
    assign bus_lock  = bus_valid && (kind_q == K_LOCKED);
    assign bus_write = (state_q == ST_LOCKW) ||
                       ((state_q == ST_SINGLE) && kind_writes(kind_q));

    // Wrapped word index: critical word first, then onward modulo the line size.
    assign fill_idx  = addr_q[IW-1:0] + beat_q;
    assign bus_addr  = in_fill ? {addr_q[AW-1:IW], fill_idx} : addr_q;
    assign bus_wdata = bus_write ? wdata_q : '0;

    assign fill_we   = in_fill && bus_ack && !bus_err;
    assign fill_data = bus_rdata;

endmodule

// File: rtl/xbac_result.sv
module xbac_result
    import xbac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fin_ok,
    input  logic          fin_abort,
    input  logic          fin_inval,
    input  logic          cap_data,
    input  logic [DW-1:0] bus_rdata,
    input  acc_kind_e     kind_q,
    input  logic          ifetch_q,
    output logic          rsp_done,
    output logic          rsp_abort,
    output logic [1:0]    rsp_code,
    output logic [DW-1:0] rsp_rdata,
    output logic          line_inval
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done   <= 1'b0;
            rsp_abort  <= 1'b0;
            rsp_code   <= AB_NONE;
            rsp_rdata  <= '0;
            line_inval <= 1'b0;
        end else begin
            rsp_done   <= fin_ok;
            rsp_abort  <= fin_abort;
            line_inval <= fin_inval;
            rsp_code   <= fin_abort ? code_for(kind_q, ifetch_q) : AB_NONE;
            if (cap_data)
                rsp_rdata <= bus_rdata;
        end
    end

endmodule

// File: rtl/xbus_abort_ctrl.sv
module xbus_abort_ctrl
    import xbac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LINE_WORDS = 4,
    localparam int IW = $clog2(LINE_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic          req_ifetch,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_done,
    output logic          rsp_abort,
    output logic [1:0]    rsp_code,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_valid,
    output logic          bus_write,
    output logic          bus_lock,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    output logic          fill_we,
    output logic [IW-1:0] fill_idx,
    output logic [DW-1:0] fill_data,
    output logic          line_inval
);

    ctl_state_e    state_q;
    acc_kind_e     kind_q;
    logic [IW-1:0] beat_q;
    logic          fin_ok, fin_abort, fin_inval, cap_data;
    logic          req_fire;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          ifetch_q;

    assign req_ready = (state_q == ST_IDLE);
    assign req_fire  = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            ifetch_q <= 1'b0;
        end else if (req_fire) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            ifetch_q <= req_ifetch;
        end
    end

    xbac_fsm #(.LINE_WORDS(LINE_WORDS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .req_kind  (acc_kind_e'(req_kind)),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .state_q   (state_q),
        .kind_q    (kind_q),
        .beat_q    (beat_q),
        .fin_ok    (fin_ok),
        .fin_abort (fin_abort),
        .fin_inval (fin_inval),
        .cap_data  (cap_data)
    );

    xbac_busdrv #(.AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)) u_busdrv (
        .state_q   (state_q),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .beat_q    (beat_q),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_lock  (bus_lock),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_data (fill_data)
    );

    xbac_result #(.DW(DW)) u_result (
        .clk        (clk),
        .rst        (rst),
        .fin_ok     (fin_ok),
        .fin_abort  (fin_abort),
        .fin_inval  (fin_inval),
        .cap_data   (cap_data),
        .bus_rdata  (bus_rdata),
        .kind_q     (kind_q),
        .ifetch_q   (ifetch_q),
        .rsp_done   (rsp_done),
        .rsp_abort  (rsp_abort),
        .rsp_code   (rsp_code),
        .rsp_rdata  (rsp_rdata),
        .line_inval (line_inval)
    );

endmodule

// File: rtl/xbac_chk.sv
module xbac_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rsp_done,
    input logic       rsp_abort,
    input logic [1:0] rsp_code,
    input logic       bus_valid,
    input logic       bus_write,
    input logic       bus_lock,
    input logic       bus_ack,
    input logic       bus_err,
    input logic       fill_we,
    input logic       line_inval
);

    // R10
    done_abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_done && rsp_abort));

    // R10
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_abort |=> !rsp_abort);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R10
    ready_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_done || rsp_abort) |-> req_ready);

    // R2
    err_stops_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_err) |=> !bus_valid);

    // R4
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_lock && bus_err) |=> !bus_lock);

    // R3
    code_with_abort_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_abort |-> (rsp_code != 2'd0));

    // R3
    code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_abort |-> (rsp_code == 2'd0));

    // R6
    fill_on_read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> (bus_valid && !bus_write && bus_ack));

    // R7
    inval_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        line_inval |=> !line_inval);

endmodule

bind xbus_abort_ctrl xbac_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .rsp_abort  (rsp_abort),
    .rsp_code   (rsp_code),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_lock   (bus_lock),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .fill_we    (fill_we),
    .line_inval (line_inval)
);

// File: tb/tb_xbus_abort_ctrl.sv
module tb_xbus_abort_ctrl;

    localparam int KRD = 0, KWD = 1, KWP = 2, KD1 = 3, KD2 = 4, KLK = 5, KFL = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic        req_ifetch = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_done, rsp_abort;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        bus_valid, bus_write, bus_lock;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic        fill_we;
    logic [1:0]  fill_idx;
    logic [31:0] fill_data;
    logic        line_inval;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xbus_abort_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_ifetch(req_ifetch), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_abort(rsp_abort),
        .rsp_code(rsp_code), .rsp_rdata(rsp_rdata), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_lock(bus_lock), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .fill_we(fill_we), .fill_idx(fill_idx),
        .fill_data(fill_data), .line_inval(line_inval)
    );

    function automatic logic [31:0] memval(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
    endfunction

    function automatic int nominal_beats(int k);
        return (k == KFL) ? 4 : (k == KLK) ? 2 : 1;
    endfunction

    function automatic int issued_beats(int k, int eb);
        return (eb >= 0 && eb < nominal_beats(k)) ? eb + 1 : nominal_beats(k);
    endfunction

    function automatic bit exp_abort(int k, int eb);
        if (k == KWP || eb < 0 || eb >= nominal_beats(k)) return 1'b0;
        if (k == KFL) return eb == 0;
        return 1'b1;
    endfunction

    function automatic logic [1:0] exp_code(int k, bit ifc);
        if (k == KD1 || k == KD2) return 2'd2;
        if (ifc && (k == KRD || k == KFL)) return 2'd3;
        return 2'd1;
    endfunction

    function automatic logic [31:0] beat_addr(int k, logic [31:0] a, int b);
        if (k == KFL) return {a[31:2], 2'(a[1:0] + 2'(b))};
        return a;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_access(input int k, input bit ifc, input logic [31:0] a,
                              input logic [31:0] wd, input int eb);
        int beat = 0;
        int cyc = 0;
        bit g_done = 0, g_abort = 0, g_inval = 0;
        logic [1:0]  g_code = '0;
        logic [31:0] g_rdata = '0;
        bit e_abort;
        @(negedge clk);
        chk(req_ready === 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_kind = 3'(k); req_ifetch = ifc; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (1) begin
            if (rsp_done || rsp_abort || line_inval) begin
                g_done = rsp_done; g_abort = rsp_abort; g_inval = line_inval;
                g_code = rsp_code; g_rdata = rsp_rdata;
                break;
            end
            if (bus_valid) begin
                if (beat < nominal_beats(k)) begin
                    // R6 R11 beat address, R5 locked beats
                    chk(bus_addr === beat_addr(k, a, beat), "R6 R11 beat address",
                        64'(bus_addr), 64'(beat_addr(k, a, beat)));
                    chk(bus_write === ((k == KWD) || (k == KWP) || (k == KLK && beat == 1)),
                        "R5 R11 beat direction", 64'(bus_write), 64'(beat));
                    chk(bus_lock === (k == KLK), "R5 lock flag", 64'(bus_lock), 64'(k == KLK));
                    if (bus_write)
                        chk(bus_wdata === wd, "R5 R11 write data", 64'(bus_wdata), 64'(wd));
                end
                bus_rdata = memval(bus_addr);
                if (beat == eb) begin bus_err = 1'b1; bus_ack = 1'b0; end
                else            begin bus_err = 1'b0; bus_ack = 1'b1; end
                #1;
                if (k == KFL) begin
                    chk(fill_we === !bus_err, "R6 fill strobe", 64'(fill_we), 64'(!bus_err));
                    if (fill_we) begin
                        chk(fill_idx === 2'(a[1:0] + 2'(beat)), "R6 fill index",
                            64'(fill_idx), 64'(2'(a[1:0] + 2'(beat))));
                        chk(fill_data === memval(bus_addr), "R6 fill data",
                            64'(fill_data), 64'(memval(bus_addr)));
                    end
                end else begin
                    chk(fill_we === 1'b0, "R6 no fill strobe", 64'(fill_we), 64'd0);
                end
                beat++;
            end else begin
                bus_ack = 1'b0; bus_err = 1'b0;
            end
            cyc++;
            if (cyc > 30) begin
                chk(1'b0, "R10 access never finished", 64'(cyc), 64'd30);
                break;
            end
            @(negedge clk);
        end
        bus_ack = 1'b0; bus_err = 1'b0;
        e_abort = exp_abort(k, eb);
        // R2 R4 R7 R8: number of beats issued before the access ended
        chk(beat == issued_beats(k, eb), "R2 R4 R7 R8 beats issued", 64'(beat), 64'(issued_beats(k, eb)));
        chk(bus_valid === 1'b0, "R2 bus idle after end", 64'(bus_valid), 64'd0);
        chk(g_abort == e_abort, "R2 R4 R7 R9 abort", 64'(g_abort), 64'(e_abort));
        chk(g_done == !e_abort, "R8 R9 R10 done", 64'(g_done), 64'(!e_abort));
        chk(g_inval == (k == KFL && eb >= 0 && eb < 4), "R7 R8 line invalidate",
            64'(g_inval), 64'(k == KFL && eb >= 0 && eb < 4));
        chk(g_code == (e_abort ? exp_code(k, ifc) : 2'd0), "R3 abort code",
            64'(g_code), 64'(e_abort ? exp_code(k, ifc) : 2'd0));
        if (g_done && k != KWD && k != KWP)
            chk(g_rdata === memval(a), "R5 R8 R11 read data", 64'(g_rdata), 64'(memval(a)));
        @(negedge clk);
        chk(!rsp_done && !rsp_abort && !line_inval, "R10 single-cycle pulse",
            64'({rsp_done, rsp_abort, line_inval}), 64'd0);
        chk(req_ready === 1'b1, "R10 ready after end", 64'(req_ready), 64'd1);
    endtask

    initial begin
        #(64'd20 * 64'd150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        chk(bus_valid === 1'b0, "R1 bus idle", 64'(bus_valid), 64'd0);
        chk({rsp_done, rsp_abort, line_inval, fill_we} === 4'b0, "R1 strobes low",
            64'({rsp_done, rsp_abort, line_inval, fill_we}), 64'd0);

        // R11 clean single accesses
        run_access(KRD, 0, 32'h0000_1000, 32'h0, -1);
        run_access(KWD, 0, 32'h0000_1004, 32'hCAFE_0001, -1);
        run_access(KWP, 0, 32'h0000_1008, 32'hCAFE_0002, -1);
        run_access(KD1, 0, 32'h0000_2000, 32'h0, -1);
        // R2 R3 errors on single accesses
        run_access(KRD, 0, 32'h0000_3000, 32'h0, 0);
        run_access(KRD, 1, 32'h0000_3004, 32'h0, 0);
        run_access(KWD, 0, 32'h0000_3008, 32'h1111_2222, 0);
        run_access(KD1, 0, 32'h0000_4000, 32'h0, 0);
        run_access(KD2, 1, 32'h0000_4004, 32'h0, 0);
        // R9 posted write error ignored
        run_access(KWP, 0, 32'h0000_5000, 32'h3333_4444, 0);
        // R4 R5 locked pair
        run_access(KLK, 0, 32'h0000_6000, 32'h5555_6666, -1);
        run_access(KLK, 0, 32'h0000_6004, 32'h7777_8888, 0);
        run_access(KLK, 0, 32'h0000_6008, 32'h9999_AAAA, 1);
        // R6 R7 R8 fills with wrapping critical word, error on each beat
        run_access(KFL, 0, 32'h0000_7002, 32'h0, -1);
        run_access(KFL, 1, 32'h0000_7103, 32'h0, -1);
        for (int b = 0; b < 4; b++) begin
            run_access(KFL, 1'(b & 1), 32'h0000_8002 + 32'(b * 16), 32'h0, b);
        end

        for (int i = 0; i < 300; i++) begin
            int k;
            int eb;
            k  = int'($urandom_range(0, 6));
            eb = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 3));
            run_access(k, 1'($urandom_range(0, 1)), $urandom(), $urandom(), eb);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule